// File: doc/BRIEF.md
# Parallel-Output Converter Interface Emulator

This block stands in for the digital face of a 16-bit converter with a parallel result bus. A controller under test can run against it without the real chip. The controller pulls the read/convert line low while chip select is low to start a conversion. It watches a busy flag, which is active low, to learn when the conversion has finished. It then reads the result over the bus, either as one 16-bit word or as two byte groups whose order a byte-select input sets.

All timing is counted in clock cycles and set by parameters: the delay before busy drops, the length of the busy-low window, and how long the previous result stays readable after a start. The results are not sampled from any signal. They come from an internal sequence register that steps by a parameterised amount after every conversion, and software-side stimulus can preload that register through a load port. Between the end of the readable window and the rise of busy, the bus carries a fixed poison word so that a controller reading too early is easy to spot. There is no real tri-state: an enable output says when the bus would be driven, and the data lines are all zero whenever that enable is low.

Top module: `padc_emu`

## Requirements
- R1: While reset is held low, and on its release, busy is high, the held result is 16'h0000 and the sequence register holds SEQ_INIT (default 0). The first conversion after reset therefore returns SEQ_INIT.
- R2: A start is a clock edge at which rc_n is sampled low, rc_n was sampled high at the previous edge, cs_n is low and no conversion is active. Busy stays high for BUSY_DLY cycles after the start edge (default 1) and then goes low.
- R3: Busy stays low for exactly CONV_CYC consecutive cycles (default 8). At the edge where it rises again, the new result is already in the output register.
- R4: For the first HOLD_CYC cycles counted from the start edge (default 5), a read returns the previous conversion result.
- R5: From that point until busy rises, an enabled bus carries POISON (default 16'hDEAD), whatever the value of byte_sel.
- R6: oe is high only when cs_n is low and rc_n is high. When oe is low, data_o is 16'h0000.
- R7: With byte_sel low, data_o[15:8] carries result bits 15..8 and data_o[7:0] carries bits 7..0. With byte_sel high, the two byte groups trade places.
- R8: Coding is straight binary. A loaded code anywhere in the full range, including 16'h0000, 16'h7FFF, 16'h8000 and 16'hFFFF, reads back unchanged after its conversion.
- R9: A falling rc_n is ignored while a conversion is active, and also whenever cs_n is high. Neither case changes busy or the next result.
- R10: Each conversion returns the sequence register, which then advances by SEQ_STEP modulo 2^16 (default step 1). A load_en pulse overwrites the sequence register but leaves the currently held result alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rc_n | input | 1 | Read (high) / convert (falling edge) control |
| cs_n | input | 1 | Active-low chip select |
| byte_sel | input | 1 | Byte-group order select |
| load_en | input | 1 | Writes load_val into the sequence register |
| load_val | input | 16 | Next conversion code to load |
| busy | output | 1 | Low while a conversion runs |
| oe | output | 1 | Bus-driven flag, standing in for tri-state |
| data_o | output | 16 | Result bus, two byte groups |

## Verification
The assertions assume that rc_n and cs_n are synchronous to clk and stable between edges. A falling edge is only seen as a start if it is present at a sampled edge, and the checks on the busy-low count assume the timing parameters keep HOLD_CYC within the active window. The stimulus changes inputs only on falling clock edges. It raises rc_n again one cycle after each falling edge, and it makes its extra rc_n pulses, and its falling edges with select high, land inside windows where the design must ignore them. It never issues a pulse narrower than one clock.

// File: rtl/padc_pkg.sv
package padc_pkg;
  localparam int WORD_W = 16;
  localparam int HALF_W = WORD_W / 2;

  function automatic logic [WORD_W-1:0] order_groups(input logic [WORD_W-1:0] w,
                                                      input logic swap);
    return swap ? {w[HALF_W-1:0], w[WORD_W-1:HALF_W]} : w;
  endfunction

  function automatic logic [WORD_W-1:0] next_code(input logic [WORD_W-1:0] w,
                                                   input logic [WORD_W-1:0] step);
    return w + step;
  endfunction
endpackage

// File: rtl/padc_timer.sv
module padc_timer #(
  parameter int BUSY_DLY = 1,
  parameter int CONV_CYC = 8,
  parameter int HOLD_CYC = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rc_n,
  input  logic cs_n,
  output logic start_ev,
  output logic done_ev,
  output logic busy,
  output logic poison_win
);
  localparam int TOT = BUSY_DLY + CONV_CYC;
  localparam int CW  = $clog2(TOT + 1);

  logic          rc_prev;
  logic          act_q;
  logic [CW-1:0] el_q;

  assign start_ev = !act_q && !cs_n && rc_prev && !rc_n;
  assign done_ev  = act_q && (el_q == CW'(TOT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rc_prev <= 1'b1;
      act_q   <= 1'b0;
      el_q    <= '0;
    end else begin
      rc_prev <= rc_n;
      if (start_ev) begin
        act_q <= 1'b1;
        el_q  <= '0;
      end else if (done_ev) begin
        act_q <= 1'b0;
        el_q  <= '0;
      end else if (act_q) begin
        el_q <= el_q + 1'b1;
      end
    end
  end

  assign busy       = !(act_q && (el_q >= CW'(BUSY_DLY)));
  assign poison_win = act_q && (el_q >= CW'(HOLD_CYC));
endmodule

// File: rtl/padc_src.sv
module padc_src
  import padc_pkg::*;
#(
  parameter logic [WORD_W-1:0] SEQ_INIT = '0,
  parameter logic [WORD_W-1:0] SEQ_STEP = WORD_W'(1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [WORD_W-1:0] load_val,
  input  logic              done_ev,
  output logic [WORD_W-1:0] result
);
  logic [WORD_W-1:0] seq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seq_q  <= SEQ_INIT;
      result <= '0;
    end else begin
      if (done_ev) result <= seq_q;
      if (load_en)      seq_q <= load_val;
      else if (done_ev) seq_q <= next_code(seq_q, SEQ_STEP);
    end
  end
endmodule

// File: rtl/padc_bus.sv
module padc_bus
  import padc_pkg::*;
#(
  parameter logic [WORD_W-1:0] POISON = 16'hDEAD
) (
  input  logic              rc_n,
  input  logic              cs_n,
  input  logic              byte_sel,
  input  logic              poison_win,
  input  logic [WORD_W-1:0] result,
  output logic              oe,
  output logic [WORD_W-1:0] data_o
);
  always_comb begin
    oe = !cs_n && rc_n;
    if (!oe)             data_o = '0;
    else if (poison_win) data_o = POISON;
    else                 data_o = order_groups(result, byte_sel);
  end
endmodule

// File: rtl/padc_emu.sv
module padc_emu
  import padc_pkg::*;
#(
  parameter int                BUSY_DLY = 1,
  parameter int                CONV_CYC = 8,
  parameter int                HOLD_CYC = 5,
  parameter logic [WORD_W-1:0] SEQ_INIT = '0,
  parameter logic [WORD_W-1:0] SEQ_STEP = WORD_W'(1),
  parameter logic [WORD_W-1:0] POISON   = 16'hDEAD
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rc_n,
  input  logic              cs_n,
  input  logic              byte_sel,
  input  logic              load_en,
  input  logic [WORD_W-1:0] load_val,
  output logic              busy,
  output logic              oe,
  output logic [WORD_W-1:0] data_o
);
  logic              start_ev;
  logic              done_ev;
  logic              poison_win;
  logic [WORD_W-1:0] result;

  padc_timer #(.BUSY_DLY(BUSY_DLY), .CONV_CYC(CONV_CYC), .HOLD_CYC(HOLD_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_n), .rc_n(rc_n), .cs_n(cs_n),
    .start_ev(start_ev), .done_ev(done_ev), .busy(busy), .poison_win(poison_win)
  );

  padc_src #(.SEQ_INIT(SEQ_INIT), .SEQ_STEP(SEQ_STEP)) u_src (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_val(load_val),
    .done_ev(done_ev), .result(result)
  );

  padc_bus #(.POISON(POISON)) u_bus (
    .rc_n(rc_n), .cs_n(cs_n), .byte_sel(byte_sel), .poison_win(poison_win),
    .result(result), .oe(oe), .data_o(data_o)
  );
endmodule

// File: rtl/padc_chk.sv
module padc_chk #(
  parameter int          CONV_CYC = 8,
  parameter logic [15:0] POISON   = 16'hDEAD
) (
  input logic        clk,
  input logic        rst_n,
  input logic        rc_n,
  input logic        busy,
  input logic        oe,
  input logic [15:0] data_o,
  input logic        start_ev,
  input logic        done_ev,
  input logic        poison_win,
  input logic [15:0] result
);
  localparam int LW = $clog2(CONV_CYC + 2);
  logic [LW-1:0] lo_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                             lo_cnt <= '0;
    else if (busy)                          lo_cnt <= '0;
    else if (lo_cnt != LW'(CONV_CYC + 1))   lo_cnt <= lo_cnt + 1'b1;
  end

  // R2
  busy_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> busy);

  // R3
  busy_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> lo_cnt == LW'(CONV_CYC));

  // R3
  done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_ev |=> busy);

  // R10
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_ev |=> $stable(result));

  // R5
  poison_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (oe && poison_win) |-> data_o == POISON);

  // R6
  idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |-> data_o == 16'h0000);

  // R6
  read_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe |-> rc_n);
endmodule

bind padc_emu padc_chk #(.CONV_CYC(CONV_CYC), .POISON(POISON)) u_chk (
  .clk(clk), .rst_n(rst_n), .rc_n(rc_n), .busy(busy), .oe(oe), .data_o(data_o),
  .start_ev(start_ev), .done_ev(done_ev), .poison_win(poison_win), .result(result)
);

// File: tb/sim_padc_emu.sv
module sim_padc_emu;
  logic        clk = 1'b0;
  logic        rst_n, rc_n, cs_n, byte_sel, load_en;
  logic [15:0] load_val;
  logic        busy, oe;
  logic [15:0] data_o;
  int          checks = 0;
  int          fails  = 0;
  bit          done   = 1'b0;

  always #4 clk = ~clk;

  padc_emu u0 (
    .clk(clk), .rst_n(rst_n), .rc_n(rc_n), .cs_n(cs_n), .byte_sel(byte_sel),
    .load_en(load_en), .load_val(load_val), .busy(busy), .oe(oe), .data_o(data_o)
  );

  // {loaded code, byte_sel, expected bus word}
  localparam logic [32:0] VEC [5] = '{
    {16'hFFFF, 1'b0, 16'hFFFF},
    {16'h8000, 1'b1, 16'h0080},
    {16'h7FFF, 1'b0, 16'h7FFF},
    {16'h12A5, 1'b1, 16'hA512},
    {16'h0000, 1'b1, 16'h0000}
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic run_conv();
    @(negedge clk);
    rc_n = 1'b0;
    step();
    rc_n = 1'b1;
    repeat (9) step();
  endtask

  task automatic load(input logic [15:0] v);
    @(negedge clk);
    load_en = 1'b1; load_val = v;
    step();
    load_en = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; rc_n = 1'b1; cs_n = 1'b1; byte_sel = 1'b0;
    load_en = 1'b0; load_val = '0;
    repeat (3) step();
    chk("R1 busy in reset", 16'(busy), 16'h1);
    chk("R6 oe deselected", 16'(oe), 16'h0);
    chk("R6 bus deselected", data_o, 16'h0000);
    cs_n = 1'b0; #1;
    chk("R6 oe reading", 16'(oe), 16'h1);
    chk("R1 reset result", data_o, 16'h0000);
    @(negedge clk); rst_n = 1'b1;
    step();
    chk("R1 busy after reset", 16'(busy), 16'h1);

    // first conversion: timeline
    @(negedge clk); rc_n = 1'b0; #1;
    chk("R6 oe low in convert", 16'(oe), 16'h0);
    step(); rc_n = 1'b1; #1;
    chk("R2 busy still high", 16'(busy), 16'h1);
    chk("R4 old data at start", data_o, 16'h0000);
    step();
    chk("R2 busy falls", 16'(busy), 16'h0);
    repeat (3) step();
    chk("R4 old data last cycle", data_o, 16'h0000);
    step();
    chk("R5 poison", data_o, 16'hDEAD);
    byte_sel = 1'b1; #1;
    chk("R5 poison swapped", data_o, 16'hDEAD);
    byte_sel = 1'b0;
    repeat (3) step();
    chk("R3 busy low last", 16'(busy), 16'h0);
    step();
    chk("R3 busy rises", 16'(busy), 16'h1);
    chk("R1 first code is init", data_o, 16'h0000);

    run_conv();
    chk("R10 step", data_o, 16'h0001);
    byte_sel = 1'b1; #1;
    chk("R7 swap", data_o, 16'h0100);
    byte_sel = 1'b0;

    load(16'h1234);
    chk("R10 load keeps result", data_o, 16'h0001);
    run_conv();
    chk("R10 loaded code", data_o, 16'h1234);
    run_conv();
    chk("R10 loaded then step", data_o, 16'h1235);

    // R9: extra falling edge mid-conversion
    @(negedge clk); rc_n = 1'b0;
    step(); rc_n = 1'b1;
    step(); step(); rc_n = 1'b0;
    step(); rc_n = 1'b1;
    repeat (6) step();
    chk("R9 busy ends on time", 16'(busy), 16'h1);
    chk("R9 single result", data_o, 16'h1236);
    step(); step();
    chk("R9 no retrigger", 16'(busy), 16'h1);

    // R9/R6: falling edge with select high
    @(negedge clk); cs_n = 1'b1; rc_n = 1'b0;
    step();
    chk("R6 bus off when deselected", data_o, 16'h0000);
    rc_n = 1'b1;
    step(); step();
    chk("R9 no start deselected", 16'(busy), 16'h1);
    cs_n = 1'b0; #1;
    chk("R9 result unchanged", data_o, 16'h1236);

    for (int i = 0; i < 5; i++) begin
      load(VEC[i][32:17]);
      run_conv();
      byte_sel = VEC[i][16]; #1;
      chk("R8 R7 table", data_o, VEC[i][15:0]);
      byte_sel = 1'b0;
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule